// File: doc/BRIEF.md
# Shared-Adder Butterfly Stage with Reorder Bank

This block is the first stage of an eight-point transform datapath. A plain two-input butterfly uses four adders and four subtractors, each busy for only part of its period. Here one adder and one subtractor do all of that work. Input words arrive one per accepted cycle. The first half of each frame is parked in a small bank of reorder registers. The counter that tracks the word position drives the write select of each register and the read select toward the shared adder and subtractor.

Each word of the second half of a frame is paired with its mirror partner from the bank. The pair is added and subtracted at once, and the result goes to registered outputs that are one bit wider than the input. The outputs carry a tag that names the pair. Because the most recently stored word is the first partner needed, the bank drains in reverse order, and the pair tags come out counting down. A dimension flag is sampled with the first word of a frame and returned with every pair of that frame, so row and column passes can share the same hardware and still be told apart downstream.

Top module: `bfly_share_top`

## Requirements
- R1: While reset is asserted, and right after it, out_valid is 0, out_sum, out_diff and out_tag are 0, out_dim is 0, and the next accepted word is word 0 of a new frame.
- R2: A frame is 2*PAIRS accepted words x0..x(2*PAIRS-1). The first PAIRS words (x0..x3 by default) are stored in the reorder bank, and the cycle after each of them is accepted out_valid is 0.
- R3: When word x(2*PAIRS-1-k) is accepted, in the next cycle out_valid is 1, out_tag is k and out_sum equals xk + x(2*PAIRS-1-k).
- R4: In that same cycle out_diff equals xk - x(2*PAIRS-1-k), with the stored word as the minuend.
- R5: out_sum and out_diff are two's-complement words of W+1 bits and hold the exact result for every pair of W-bit inputs, including the most negative and most positive values.
- R6: Within a frame the tags come out in the order PAIRS-1 down to 0. After word 2*PAIRS-1 the next accepted word is x0 of the next frame, so the schedule repeats every 2*PAIRS accepted words (eight by default).
- R7: A cycle with in_valid at 0 accepts no word and does not advance the schedule. In the next cycle out_valid is 0 and out_sum, out_diff, out_tag and out_dim keep their previous values.
- R8: out_dim equals the in_dim value sampled together with x0 of the frame. in_dim has no effect on any other word of the frame.
- R9: A stored word is not disturbed by stalls or by other words being stored. Pairs released after a stall still use the original xk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Word strobe; high means in_word is accepted this cycle |
| in_word | input | W | Signed input word |
| in_dim | input | 1 | Dimension flag, sampled with word 0 of a frame |
| out_valid | output | 1 | A new sum/difference pair is present |
| out_sum | output | W+1 | Signed sum of the current pair |
| out_diff | output | W+1 | Signed difference of the current pair (stored minus live) |
| out_tag | output | $clog2(PAIRS) | Index k of the current pair |
| out_dim | output | 1 | Dimension flag of the frame the pair belongs to |

## Verification
The bench builds the block with W = 8 and PAIRS = 4. The narrow word makes the extreme operands -128 and 127 easy to write into the vector table, so sums of -256 and differences of 255 show whether the extra output bit is carried correctly. With four pairs, the full descending tag order and the wrap into the next frame both fall inside short frames. Stalls are placed in both the capture half and the release half of a frame. A reset in the middle of a frame checks that the schedule restarts at word 0.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Half of a frame the slot counter is in.
  typedef enum logic {
    PH_CAPTURE = 1'b0,
    PH_RELEASE = 1'b1
  } phase_e;

  // Sign-extend a W-bit word by one bit, returned in a 64-bit container.
  function automatic logic [63:0] sext1(input logic [63:0] v, input int w);
    logic [63:0] r;
    r = v;
    for (int i = w; i < 64; i++) r[i] = v[w-1];
    return r;
  endfunction

endpackage

// File: rtl/bfly_slot_ctrl.sv
module bfly_slot_ctrl #(
  parameter int PAIRS = 4,
  localparam int N  = 2 * PAIRS,
  localparam int CW = $clog2(N),
  localparam int SW = $clog2(PAIRS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_dim,
  output logic [PAIRS-1:0] cap_en,
  output logic             rel_en,
  output logic [SW-1:0]    rel_idx,
  output logic             frame_dim
);
  import bfly_pkg::*;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dim_q, dim_d;
  phase_e        phase;

  // Word position inside the frame.
  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) begin
      if (cnt_q == CW'(N - 1)) cnt_d = '0;
      else                     cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign phase = (cnt_q < CW'(PAIRS)) ? PH_CAPTURE : PH_RELEASE;

  // Write selects for the reorder bank: one register per capture slot.
  for (genvar k = 0; k < PAIRS; k++) begin : g_cap
    assign cap_en[k] = in_valid && (phase == PH_CAPTURE) && (cnt_q == CW'(k));
  end

  // Release: pair the live word with its mirror partner.
  assign rel_en  = in_valid && (phase == PH_RELEASE);
  assign rel_idx = SW'(CW'(N - 1) - cnt_q);

  // Dimension flag belongs to the frame and is taken with word 0.
  always_comb begin
    dim_d = dim_q;
    if (cap_en[0]) dim_d = in_dim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dim_q <= 1'b0;
    else        dim_q <= dim_d;
  end

  assign frame_dim = dim_q;

  // R6: the last word of a frame is followed by word 0.
  a_r6_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_q == CW'(N - 1)) |=> (cnt_q == '0));

  // R7: a stall cycle does not move the schedule.
  a_r7_stall_holds_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

  // R2: at most one reorder register is written in any cycle.
  a_r2_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_en));

endmodule

// File: rtl/bfly_reorder_bank.sv
module bfly_reorder_bank #(
  parameter int W     = 12,
  parameter int PAIRS = 4,
  localparam int SW   = $clog2(PAIRS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     in_word,
  input  logic [PAIRS-1:0] cap_en,
  input  logic [SW-1:0]    rel_idx,
  output logic [W-1:0]     rd_word
);

  logic [W-1:0] slot_q [PAIRS];
  logic [W-1:0] slot_d [PAIRS];

  for (genvar k = 0; k < PAIRS; k++) begin : g_slot
    always_comb begin
      slot_d[k] = slot_q[k];
      if (cap_en[k]) slot_d[k] = in_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[k] <= '0;
      else        slot_q[k] <= slot_d[k];
    end

    // R9: a stored word changes only when its own select is active.
    a_r9_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en[k] |=> $stable(slot_q[k]));
  end

  // Read mux toward the shared adder/subtractor.
  always_comb begin
    rd_word = slot_q[0];
    for (int k = 1; k < PAIRS; k++) begin
      if (rel_idx == SW'(k)) rd_word = slot_q[k];
    end
  end

endmodule

// File: rtl/bfly_addsub_out.sv
module bfly_addsub_out #(
  parameter int W     = 12,
  parameter int PAIRS = 4,
  localparam int SW   = $clog2(PAIRS),
  localparam int OW   = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rel_en,
  input  logic [SW-1:0] rel_idx,
  input  logic          frame_dim,
  input  logic [W-1:0]  lo_word,
  input  logic [W-1:0]  hi_word,
  output logic          out_valid,
  output logic [OW-1:0] out_sum,
  output logic [OW-1:0] out_diff,
  output logic [SW-1:0] out_tag,
  output logic          out_dim
);
  import bfly_pkg::*;

  logic [OW-1:0] lo_x, hi_x;
  logic [63:0]   lo_e, hi_e;
  logic [OW-1:0] sum_d, diff_d, sum_q, diff_q;
  logic [SW-1:0] tag_d, tag_q;
  logic          dim_d, dim_q, vld_q;

  assign lo_e = sext1(64'(lo_word), W);
  assign hi_e = sext1(64'(hi_word), W);
  assign lo_x = lo_e[OW-1:0];
  assign hi_x = hi_e[OW-1:0];

  // The single shared adder and subtractor.
  always_comb begin
    sum_d  = sum_q;
    diff_d = diff_q;
    tag_d  = tag_q;
    dim_d  = dim_q;
    if (rel_en) begin
      sum_d  = lo_x + hi_x;
      diff_d = lo_x - hi_x;
      tag_d  = rel_idx;
      dim_d  = frame_dim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      diff_q <= '0;
      tag_q  <= '0;
      dim_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      diff_q <= diff_d;
      tag_q  <= tag_d;
      dim_q  <= dim_d;
      vld_q  <= rel_en;
    end
  end

  assign out_valid = vld_q;
  assign out_sum   = sum_q;
  assign out_diff  = diff_q;
  assign out_tag   = tag_q;
  assign out_dim   = dim_q;

  // R5: sum and difference of the same operands share their lowest bit.
  a_r5_sum_diff_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sum[0] == out_diff[0]));

endmodule

// File: rtl/bfly_share_top.sv
module bfly_share_top #(
  parameter int W     = 12,
  parameter int PAIRS = 4,
  localparam int SW   = $clog2(PAIRS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_word,
  input  logic          in_dim,
  output logic          out_valid,
  output logic [W:0]    out_sum,
  output logic [W:0]    out_diff,
  output logic [SW-1:0] out_tag,
  output logic          out_dim
);

  logic [PAIRS-1:0] cap_en;
  logic             rel_en;
  logic [SW-1:0]    rel_idx;
  logic             frame_dim;
  logic [W-1:0]     rd_word;

  bfly_slot_ctrl #(.PAIRS(PAIRS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dim    (in_dim),
    .cap_en    (cap_en),
    .rel_en    (rel_en),
    .rel_idx   (rel_idx),
    .frame_dim (frame_dim)
  );

  bfly_reorder_bank #(.W(W), .PAIRS(PAIRS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_word (in_word),
    .cap_en  (cap_en),
    .rel_idx (rel_idx),
    .rd_word (rd_word)
  );

  bfly_addsub_out #(.W(W), .PAIRS(PAIRS)) u_addsub (
    .clk       (clk),
    .rst_n     (rst_n),
    .rel_en    (rel_en),
    .rel_idx   (rel_idx),
    .frame_dim (frame_dim),
    .lo_word   (rd_word),
    .hi_word   (in_word),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_diff  (out_diff),
    .out_tag   (out_tag),
    .out_dim   (out_dim)
  );

  // R6: back-to-back pairs come out with tags counting down by one.
  a_r6_tag_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> ((out_tag + SW'(1)) == $past(out_tag)));

  // R7: no pair can appear in the cycle after a stall.
  a_r7_no_pair_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

// File: tb/tb_bfly_share_top.sv
`timescale 1ns/1ps
module tb_bfly_share_top;
  localparam int W     = 8;
  localparam int PAIRS = 4;
  localparam int N     = 2 * PAIRS;
  localparam int SW    = $clog2(PAIRS);
  localparam int NF    = 6;

  // Stimulus table: one frame per row; expected values follow from R3/R4.
  localparam int FRAMES [NF][N] = '{
    '{   1,    2,    3,    4,    5,    6,    7,    8},
    '{  -1,   -2,   -3,   -4,   -5,   -6,   -7,   -8},
    '{ 127,  127,  127,  127,  127,  127,  127,  127},
    '{-128, -128, -128, -128, -128, -128, -128, -128},
    '{ 127, -128,  127, -128,  127, -128,  127, -128},
    '{   0,  100, -100,   37,  -37,   55,  -90,    0}
  };
  localparam bit FDIM [NF] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  in_word;
  logic          in_dim;
  logic          out_valid;
  logic [W:0]    out_sum;
  logic [W:0]    out_diff;
  logic [SW-1:0] out_tag;
  logic          out_dim;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bfly_share_top #(.W(W), .PAIRS(PAIRS)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_dim    (in_dim),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_diff  (out_diff),
    .out_tag   (out_tag),
    .out_dim   (out_dim)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic push(input bit v, input int w, input bit d);
    in_valid = v;
    in_word  = w[W-1:0];
    in_dim   = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    check({req, " out_valid"}, int'(out_valid), 0);
  endtask

  task automatic check_pair(input string req, input int xk, input int xm, input int k, input bit d);
    check({req, " out_valid"}, int'(out_valid), 1);
    check({req, " out_tag"},   int'(out_tag), k);
    check({req, " out_sum"},   int'($signed(out_sum)), xk + xm);
    check({req, " out_diff"},  int'($signed(out_diff)), xk - xm);
    check({req, " out_dim"},   int'(out_dim), int'(d));
  endtask

  // Plays one table frame; in_dim is inverted on every word but x0 (R8).
  task automatic run_frame(input int f);
    for (int i = 0; i < N; i++) begin
      push(1'b1, FRAMES[f][i], (i == 0) ? FDIM[f] : ~FDIM[f]);
      if (i < PAIRS) check_idle("R2 capture half");
      else check_pair("R3 R4 R5 R6 R8 release", FRAMES[f][N-1-i], FRAMES[f][i], N - 1 - i, FDIM[f]);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    in_dim   = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state.
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_sum",   int'(out_sum), 0);
    check("R1 out_diff",  int'(out_diff), 0);
    check("R1 out_tag",   int'(out_tag), 0);
    check("R1 out_dim",   int'(out_dim), 0);
    rst_n = 1'b1;

    // Table walk, frames back to back (R6 wrap between them).
    for (int f = 0; f < NF; f++) run_frame(f);

    // R7 / R9: stalls in capture and release halves.
    push(1'b1, 10, 1'b1);  check_idle("R2 stall frame x0");
    push(1'b1, -20, 1'b0); check_idle("R2 stall frame x1");
    push(1'b0, 99, 1'b0);  check_idle("R7 stall in capture");
    push(1'b1, 30, 1'b0);  check_idle("R2 stall frame x2");
    push(1'b1, -40, 1'b0); check_idle("R2 stall frame x3");
    push(1'b0, 77, 1'b0);  check_idle("R7 stall before release");
    push(1'b1, 5, 1'b0);   check_pair("R9 after stalls", -40, 5, 3, 1'b1);
    push(1'b0, 11, 1'b0);
    check_idle("R7 stall in release");
    check("R7 sum held",  int'($signed(out_sum)), -35);
    check("R7 diff held", int'($signed(out_diff)), -45);
    check("R7 tag held",  int'(out_tag), 3);
    check("R7 dim held",  int'(out_dim), 1);
    push(1'b1, 6, 1'b0);   check_pair("R9 x2 pair", 30, 6, 2, 1'b1);
    push(1'b1, -7, 1'b0);  check_pair("R9 x1 pair", -20, -7, 1, 1'b1);
    push(1'b1, 8, 1'b0);   check_pair("R9 x0 pair", 10, 8, 0, 1'b1);

    // R1: reset in the middle of a frame restarts the schedule.
    push(1'b1, 1, 1'b1);
    push(1'b1, 2, 1'b0);
    push(1'b1, 3, 1'b0);
    push(1'b1, 4, 1'b0);
    push(1'b1, 50, 1'b0);  check_pair("R3 before mid reset", 4, 50, 3, 1'b1);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 mid reset out_valid", int'(out_valid), 0);
    check("R1 mid reset out_sum",   int'(out_sum), 0);
    check("R1 mid reset out_dim",   int'(out_dim), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(4);

    summary();
    $finish;
  end

endmodule